// File: doc/BRIEF.md
# Mode-Steered Output Router and Sample Shaper

This block sits at the output of a two-leg sample processor. It takes one sample from the upper leg and one from the lower leg on each valid input beat and sends them to two 16-bit output ports, A and B. A 2-bit operating mode and an interleave-select input decide the routing. The legs can be added together onto A, passed straight through to A and B, or put one after the other onto A, upper leg first. In that last case one input beat gives two output beats.

The input samples are wider than the ports, which leaves headroom for arithmetic growth. Each routed value is rounded to a precision set by a 3-bit code. It is then clamped to the signed 16-bit range. Finally it is sent out either as two's complement or as offset binary. Whenever port B carries no data, it is held at all zeros.

Top module: `outstage_router`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and both `out_a` and `out_b` are 0 until the first input beat.
- R2: Mode 2'b00 sums the two legs. `out_a` carries the shaped sum, `out_b` is zero, and one output beat follows each input beat.
- R3: Mode 2'b10 passes the legs through. `out_a` carries the shaped upper leg and `out_b` the shaped lower leg in the same beat.
- R4: In mode 2'b01 or 2'b11 with `int_mux` high, each input beat gives two output beats on consecutive cycles. The first carries the shaped upper leg on `out_a` and the second the shaped lower leg. Input beats in this configuration come at most every other cycle.
- R5: In mode 2'b01 or 2'b11 with `int_mux` low, `out_a` carries the shaped upper leg and `out_b` the shaped lower leg in a single beat.
- R6: Round code c drops min(c, 8) low bits of the 16-bit result. Code 0 keeps 16 bits and code 7 keeps 9 bits. Rounding adds half of the kept LSB (2^(d-1)), so ties round toward plus infinity, and then clears the d dropped bits.
- R7: After rounding, the value is clamped to the range -32768 to 32767. The upper clamp is 32767 even when bits below the kept precision are then nonzero.
- R8: With `fmt_offset` low, the result is two's complement. With it high, bit 15 of the clamped result is inverted (offset binary).
- R9: In mode 2'b00, and in the interleaved configuration of R4, `out_b` is all zeros on every output beat, whatever the value of `fmt_offset`.
- R10: An output beat appears in the cycle after the clock edge that captures an input beat. `out_valid` is low in every other cycle except the second beat of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat qualifier |
| in_up | input | IN_W (20) | Upper-leg sample, signed, in output LSB units |
| in_lo | input | IN_W (20) | Lower-leg sample, signed, in output LSB units |
| mode | input | 2 | Operating mode; bit 0 set means an interpolating mode |
| int_mux | input | 1 | 1: interleave on port A; 0: legs to A and B |
| fmt_offset | input | 1 | 0: two's complement; 1: offset binary |
| rnd_code | input | RND_W (3) | Number of low result bits to round away |
| out_valid | output | 1 | Output beat qualifier |
| out_a | output | OUT_W (16) | Port A sample |
| out_b | output | OUT_W (16) | Port B sample, zero when unused |

## Verification
The assertions take two things for granted. First, `mode`, `int_mux`, `fmt_offset` and `rnd_code` hold still from an input beat until its last output beat has left. Second, in the interleaved configuration no input beat follows another in the next cycle. The bench meets both. It changes the configuration only after the output has gone idle, and after each input beat it waits two or three cycles before sending the next.

// File: rtl/osr_pkg.sv
package osr_pkg;

   typedef enum logic [1:0] {
      OSR_SUM    = 2'b00,
      OSR_INTERP = 2'b01,
      OSR_SPLIT  = 2'b10,
      OSR_Q2R    = 2'b11
   } osr_mode_e;

   // Bit 0 of the mode marks the interpolating modes
   function automatic logic osr_is_interp(input logic [1:0] m);
      return m[0];
   endfunction

   // One input beat becomes two output beats on port A
   function automatic logic osr_two_beat(input logic [1:0] m, input logic ilv);
      return m[0] & ilv;
   endfunction

   // Port B carries data only when it is routed a leg
   function automatic logic osr_b_used(input logic [1:0] m, input logic ilv);
      return (m == OSR_SPLIT) || (m[0] && !ilv);
   endfunction

endpackage

// File: rtl/osr_route.sv
module osr_route #(
   parameter int IN_W  = 20,
   parameter int SUM_W = IN_W + 1
) (
   input  logic [1:0]             mode,
   input  logic                   int_mux,
   input  logic signed [IN_W-1:0] leg_up,
   input  logic signed [IN_W-1:0] leg_lo,
   output logic signed [SUM_W-1:0] lane_a,
   output logic signed [SUM_W-1:0] lane_b,
   output logic                    b_used
);
   import osr_pkg::*;

   localparam int EXT = SUM_W - IN_W;

   logic signed [SUM_W-1:0] up_x, lo_x;

   assign up_x = {{EXT{leg_up[IN_W-1]}}, leg_up};
   assign lo_x = {{EXT{leg_lo[IN_W-1]}}, leg_lo};

   always_comb begin
      lane_a = up_x;
      lane_b = lo_x;
      b_used = osr_b_used(mode, int_mux);
      unique case (osr_mode_e'(mode))
         OSR_SUM: begin
            lane_a = up_x + lo_x;
            lane_b = '0;
         end
         OSR_SPLIT: begin
            lane_a = up_x;
            lane_b = lo_x;
         end
         OSR_INTERP, OSR_Q2R: begin
            lane_a = up_x;
            lane_b = int_mux ? '0 : lo_x;
         end
         default: begin
            lane_a = up_x;
            lane_b = '0;
         end
      endcase
   end

endmodule

// File: rtl/osr_shape.sv
module osr_shape #(
   parameter int W        = 21,
   parameter int OUT_W    = 16,
   parameter int RND_W    = 3,
   parameter int MIN_PREC = 8
) (
   input  logic signed [W-1:0] din,
   input  logic [RND_W-1:0]    rnd_code,
   input  logic                fmt_offset,
   output logic [OUT_W-1:0]    dout
);
   localparam int MAXD = OUT_W - MIN_PREC;
   localparam int WX   = W + 2;
   localparam logic signed [WX-1:0] HI = {{(WX-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [WX-1:0] LO = ~HI;

   logic signed [WX-1:0] xe, rounded;
   logic [OUT_W-1:0]     clamped;

   assign xe = {{2{din[W-1]}}, din};

   generate
      if (MAXD == 0) begin : g_fixed
         assign rounded = xe;
      end else begin : g_round
         localparam int DW = $clog2(MAXD + 1);
         logic [DW-1:0]        drop;
         logic signed [WX-1:0] half, keep_mask;
         always_comb begin
            if (int'(rnd_code) > MAXD) drop = DW'(MAXD);
            else                       drop = DW'(rnd_code);
            half      = (drop == '0) ? '0 : (WX'(1) << (drop - DW'(1)));
            keep_mask = ~((WX'(1) << drop) - WX'(1));
         end
         assign rounded = (xe + half) & keep_mask;
      end
   endgenerate

   always_comb begin
      if (rounded > HI)      clamped = HI[OUT_W-1:0];
      else if (rounded < LO) clamped = LO[OUT_W-1:0];
      else                   clamped = rounded[OUT_W-1:0];
   end

   assign dout = clamped ^ {fmt_offset, {(OUT_W-1){1'b0}}};

endmodule

// File: rtl/outstage_router.sv
module outstage_router #(
   parameter int IN_W     = 20,
   parameter int OUT_W    = 16,
   parameter int RND_W    = 3,
   parameter int MIN_PREC = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [IN_W-1:0]     in_up,
   input  logic [IN_W-1:0]     in_lo,
   input  logic [1:0]          mode,
   input  logic                int_mux,
   input  logic                fmt_offset,
   input  logic [RND_W-1:0]    rnd_code,
   output logic                out_valid,
   output logic [OUT_W-1:0]    out_a,
   output logic [OUT_W-1:0]    out_b
);
   import osr_pkg::*;

   localparam int SUM_W = IN_W + 1;
   localparam int LANES = 2;

   if (IN_W < OUT_W) begin : g_bad_width
      $error("IN_W must be at least OUT_W");
   end
   if (MIN_PREC < 1 || MIN_PREC > OUT_W) begin : g_bad_prec
      $error("MIN_PREC must lie in 1..OUT_W");
   end
   if (RND_W < 1) begin : g_bad_rnd
      $error("RND_W must be at least 1");
   end

   logic signed [SUM_W-1:0] route_a, route_b;
   logic                    route_b_used;
   logic                    pend_q;
   logic signed [IN_W-1:0]  hold_q;
   logic signed [SUM_W-1:0] lane_in  [LANES];
   logic [OUT_W-1:0]        lane_out [LANES];
   logic                    second_beat;

   osr_route #(.IN_W(IN_W), .SUM_W(SUM_W)) u_route (
      .mode    (mode),
      .int_mux (int_mux),
      .leg_up  (in_up),
      .leg_lo  (in_lo),
      .lane_a  (route_a),
      .lane_b  (route_b),
      .b_used  (route_b_used)
   );

   assign second_beat = pend_q && !in_valid;

   always_comb begin
      lane_in[0] = second_beat ? {hold_q[IN_W-1], hold_q} : route_a;
      lane_in[1] = route_b;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      osr_shape #(
         .W(SUM_W), .OUT_W(OUT_W), .RND_W(RND_W), .MIN_PREC(MIN_PREC)
      ) u_shape (
         .din        (lane_in[g]),
         .rnd_code   (rnd_code),
         .fmt_offset (fmt_offset),
         .dout       (lane_out[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_a     <= '0;
         out_b     <= '0;
         pend_q    <= 1'b0;
         hold_q    <= '0;
      end else if (in_valid) begin
         out_valid <= 1'b1;
         out_a     <= lane_out[0];
         out_b     <= route_b_used ? lane_out[1] : '0;
         pend_q    <= osr_two_beat(mode, int_mux);
         hold_q    <= in_lo;
      end else if (pend_q) begin
         out_valid <= 1'b1;
         out_a     <= lane_out[0];
         out_b     <= '0;
         pend_q    <= 1'b0;
      end else begin
         out_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/osr_check.sv
module osr_check #(
   parameter int OUT_W    = 16,
   parameter int RND_W    = 3,
   parameter int MIN_PREC = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       mode,
   input logic             int_mux,
   input logic             fmt_offset,
   input logic [RND_W-1:0] rnd_code,
   input logic             out_valid,
   input logic [OUT_W-1:0] out_a,
   input logic [OUT_W-1:0] out_b
);
   localparam int MAXD = OUT_W - MIN_PREC;

   logic             two_beat, b_idle, prev_two;
   logic [OUT_W-1:0] plain_a, low_mask;

   assign two_beat = mode[0] & int_mux;
   assign b_idle   = (mode == 2'b00) || two_beat;
   assign plain_a  = out_a ^ {fmt_offset, {(OUT_W-1){1'b0}}};

   always_comb begin
      low_mask = '0;
      for (int i = 0; i < OUT_W; i++) begin
         if (i < MAXD && i < int'(rnd_code)) low_mask[i] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_two <= 1'b0;
      else        prev_two <= in_valid && two_beat;
   end

   AST_INPUT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && two_beat) |=> !in_valid); // R4
   AST_PAIR_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && two_beat) |=> out_valid ##1 out_valid); // R4
   AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !two_beat) |=> out_valid); // R10
   AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !prev_two) |=> !out_valid); // R10
   AST_B_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && b_idle) |-> (out_b == '0)); // R9
   AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (((plain_a & low_mask) == '0) ||
                     (plain_a == {1'b0, {(OUT_W-1){1'b1}}}))); // R6

endmodule

bind outstage_router osr_check #(
   .OUT_W(OUT_W), .RND_W(RND_W), .MIN_PREC(MIN_PREC)
) u_osr_check (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .mode       (mode),
   .int_mux    (int_mux),
   .fmt_offset (fmt_offset),
   .rnd_code   (rnd_code),
   .out_valid  (out_valid),
   .out_a      (out_a),
   .out_b      (out_b)
);

// File: tb/tb_outstage_router.sv
module tb_outstage_router;
   localparam int IN_W = 20;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [IN_W-1:0] in_up = '0;
   logic [IN_W-1:0] in_lo = '0;
   logic [1:0]      mode = 2'b00;
   logic            int_mux = 1'b0;
   logic            fmt_offset = 1'b0;
   logic [2:0]      rnd_code = '0;
   logic            out_valid;
   logic [15:0]     out_a, out_b;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   outstage_router dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_up(in_up),
      .in_lo(in_lo), .mode(mode), .int_mux(int_mux), .fmt_offset(fmt_offset),
      .rnd_code(rnd_code), .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
   );

   // Arithmetic model of rounding, clamping and output format (R6, R7, R8)
   function automatic logic [15:0] shape(input longint x, input int code, input bit ofs);
      int d = (code > 8) ? 8 : code;
      longint v = x;
      logic [15:0] r;
      if (d > 0) v = v + (longint'(1) <<< (d - 1));
      v = (v >>> d) <<< d;
      if (v > 32767) v = 32767;
      if (v < -32768) v = -32768;
      r = v[15:0];
      if (ofs) r[15] = ~r[15];
      return r;
   endfunction

   task automatic check_beat(input string req, input logic [15:0] ea, input logic [15:0] eb);
      checks++;
      if (out_valid !== 1'b1 || out_a !== ea || out_b !== eb) begin
         errors++;
         $display("FAIL %s: valid=%0b a=%h b=%h expected valid=1 a=%h b=%h (mode=%b int=%0b fmt=%0b rnd=%0d)",
                  req, out_valid, out_a, out_b, ea, eb, mode, int_mux, fmt_offset, rnd_code);
      end
   endtask

   task automatic check_idle(input string req);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL %s: valid=%0b expected 0", req, out_valid);
      end
   endtask

   task automatic send(input longint u, input longint l);
      longint s = u + l;
      int c = int'(rnd_code);
      bit ofs = fmt_offset;
      @(negedge clk);
      in_valid = 1'b1;
      in_up = u[IN_W-1:0];
      in_lo = l[IN_W-1:0];
      @(negedge clk);
      in_valid = 1'b0;
      if (mode == 2'b00) begin
         check_beat("R2 sum on A, R9 B zero", shape(s, c, ofs), 16'h0000);
      end else if (mode == 2'b10) begin
         check_beat("R3 split legs", shape(u, c, ofs), shape(l, c, ofs));
      end else if (int_mux) begin
         check_beat("R4 first beat upper leg", shape(u, c, ofs), 16'h0000);
         @(negedge clk);
         check_beat("R4 second beat lower leg", shape(l, c, ofs), 16'h0000);
      end else begin
         check_beat("R5 external interleave", shape(u, c, ofs), shape(l, c, ofs));
      end
      @(negedge clk);
      check_idle("R10 no extra beat");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      longint vu[12];
      longint vl[12];
      vu[0] = 0;        vl[0] = 0;
      vu[1] = 8;        vl[1] = -8;
      vu[2] = 32767;    vl[2] = -32768;
      vu[3] = 32760;    vl[3] = 100;
      vu[4] = 40000;    vl[4] = -40000;
      vu[5] = 524287;   vl[5] = -524288;
      vu[6] = -524288;  vl[6] = -524288;
      vu[7] = -129;     vl[7] = 127;
      for (int k = 8; k < 12; k++) begin
         vu[k] = ((k * 7919 + 13) % 70000) - 35000;
         vl[k] = ((k * 104729 + 7) % 66000) - 33000;
      end

      repeat (3) @(negedge clk);
      checks++; // R1 reset state
      if (out_valid !== 1'b0 || out_a !== 16'h0 || out_b !== 16'h0) begin
         errors++;
         $display("FAIL R1 in reset: valid=%0b a=%h b=%h expected 0 0 0", out_valid, out_a, out_b);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      checks++; // R1 after release
      if (out_valid !== 1'b0 || out_a !== 16'h0 || out_b !== 16'h0) begin
         errors++;
         $display("FAIL R1 after release: valid=%0b a=%h b=%h expected 0 0 0", out_valid, out_a, out_b);
      end

      // Sweep every mode, interleave select, format and round code (R6, R7, R8)
      for (int m = 0; m < 4; m++) begin
         for (int im = 0; im < 2; im++) begin
            for (int f = 0; f < 2; f++) begin
               for (int r = 0; r < 8; r++) begin
                  mode = 2'(m);
                  int_mux = im[0];
                  fmt_offset = f[0];
                  rnd_code = 3'(r);
                  for (int k = 0; k < 12; k++) send(vu[k], vl[k]);
               end
            end
         end
      end

      // R6 tie cases: +8 and -8 at four dropped bits, split mode
      mode = 2'b10; int_mux = 1'b0; fmt_offset = 1'b0; rnd_code = 3'd4;
      @(negedge clk);
      in_valid = 1'b1; in_up = 20'd8; in_lo = -20'sd8;
      @(negedge clk);
      in_valid = 1'b0;
      check_beat("R6 ties round upward", 16'h0010, 16'h0000);
      @(negedge clk);
      check_idle("R10 idle after tie test");

      // R7 positive clamp keeps 0x7FFF; R8 offset binary of negative clamp is 0x0000
      mode = 2'b10; fmt_offset = 1'b1; rnd_code = 3'd7;
      @(negedge clk);
      in_valid = 1'b1; in_up = 20'd50000; in_lo = -20'sd50000;
      @(negedge clk);
      in_valid = 1'b0;
      check_beat("R7 clamp both ends, R8 offset", 16'hFFFF, 16'h0000);
      @(negedge clk);
      check_idle("R10 idle after clamp test");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule